// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block carries out the set-vector-length operation of a vector core. Each request brings an application vector length (AVL) and an 8-bit type immediate. A dialect select input says which of two immediate bit layouts the immediate uses. The block decodes element width (SEW) and register grouping (LMUL) from that layout and checks that the combination is legal. It then grants a vector length of min(AVL, VLMAX), where VLMAX = VLEN × LMUL / SEW. The granted length and the resulting type word are held in registers, and later vector instructions read them.

Only integral grouping is supported. SEW may be 8, 16 or 32, and LMUL may be 1, 2, 4 or 8. Any other setting makes the configuration illegal. This covers fractional grouping, reserved width codes, and a non-zero value in the older layout's element-divide field. An illegal configuration holds a granted length of zero and a type word that has only its illegal flag set. A separate output tells the floating-point path whether it may run, which is only when the held configuration is legal with 32-bit elements.

The immediates that select 8-bit elements at each of the four groupings are the same in both layouts. Code that uses only those settings therefore runs unchanged under either dialect.

Top module: `vcfg_unit`

## Requirements
- R1: After reset, vl_o is 0, vtype_o has only bit XLEN-1 set, fp_ok_o is 0 and ack_o is 0.
- R2: A request presented with req_valid high at a clock edge updates vl_o, vtype_o and fp_ok_o at that edge, and ack_o is high for exactly the following cycle. While req_valid is low, vl_o, vtype_o and fp_ok_o hold their values and ack_o is 0, whatever the other request inputs do.
- R3: The width code maps 0 to SEW=8, 1 to SEW=16 and 2 to SEW=32, and codes 3 to 7 are illegal. The grouping code maps 0, 1, 2 and 3 to LMUL 1, 2, 4 and 8.
- R4: When req_ratified is 0, the immediate uses the older layout: grouping in bits 1:0, width in bits 4:2 and the element-divide field in bits 6:5. A non-zero element-divide field, or bit 7 set, makes the request illegal.
- R5: When req_ratified is 1, the immediate uses the newer layout: grouping in bits 2:0, width in bits 5:3, tail policy in bit 6 and mask policy in bit 7. Grouping codes 4 to 7 (fractional or reserved) are illegal.
- R6: For a legal request, vl_o = min(req_avl, VLEN × LMUL / SEW). With VLEN=128, SEW=8 and LMUL=1 this is min(AVL, 16).
- R7: For an illegal request, vl_o becomes 0 and vtype_o becomes a word with only bit XLEN-1 (the illegal flag) set.
- R8: After a legal request, vtype_o holds the grouping code in bits 2:0, the width code in bits 5:3, the tail policy in bit 6 and the mask policy in bit 7, with every other bit 0. Both policy bits are 0 in the older dialect.
- R9: fp_ok_o is 1 exactly when the held configuration is legal with SEW=32.
- R10: Immediates 0 to 3 (SEW=8, LMUL 1 to 8) give the same vl_o and vtype_o in both dialects.
- R11: Across the two dialects, exactly 24 width/grouping combinations are legal, 12 in each. Of the 256 immediates, 12 are legal in the older dialect and 48 are legal in the newer one, because the two policy bits are free there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one configuration per cycle |
| req_ratified | input | 1 | Layout select: 0 older layout, 1 newer layout |
| req_avl | input | XLEN | Requested element count |
| req_vtypei | input | 8 | Type immediate |
| ack_o | output | 1 | High for one cycle after each accepted request |
| vl_o | output | XLEN | Held granted vector length |
| vtype_o | output | XLEN | Held type word, illegal flag in bit XLEN-1 |
| fp_ok_o | output | 1 | Held configuration permits floating-point operation |

## Verification
The bench builds the block with VLEN=128 and XLEN=32. At these values VLMAX ranges from 4 (SEW=32, LMUL=1) up to 128 (SEW=8, LMUL=8), so AVL values just below, at and just above every grant limit take only a few cycles each. A full sweep of all 256 immediates in both dialects is also short enough to run completely. A 32-bit AVL lets the bench test the largest request value, 0xFFFFFFFF, and check that the grant clamps it.

// File: rtl/vcfg_pkg.sv
`timescale 1ns/1ps
package vcfg_pkg;

  localparam int IMM_W = 8;

  // Decoded configuration: log2 of element bytes and log2 of grouping.
  typedef struct packed {
    logic       legal;
    logic [1:0] sew_log;
    logic [1:0] lmul_log;
    logic       ta;
    logic       ma;
  } cfg_t;

  // Older layout: grouping [1:0], width [4:2], element-divide [6:5], [7] reserved.
  function automatic cfg_t decode_older(input logic [IMM_W-1:0] imm);
    cfg_t c;
    c = '0;
    if (imm[7:5] == 3'b000 && imm[4:2] < 3'd3) begin
      c.legal    = 1'b1;
      c.sew_log  = imm[3:2];
      c.lmul_log = imm[1:0];
    end
    return c;
  endfunction

  // Newer layout: grouping [2:0], width [5:3], tail policy [6], mask policy [7].
  function automatic cfg_t decode_newer(input logic [IMM_W-1:0] imm);
    cfg_t c;
    c = '0;
    if (imm[5:3] < 3'd3 && !imm[2]) begin
      c.legal    = 1'b1;
      c.sew_log  = imm[4:3];
      c.lmul_log = imm[1:0];
      c.ta       = imm[6];
      c.ma       = imm[7];
    end
    return c;
  endfunction

  // Maximum elements for a register group: bytes per register, scaled by
  // grouping, divided by element bytes.
  function automatic int unsigned vlmax_of(input int unsigned vlen,
                                           input logic [1:0] sew_log,
                                           input logic [1:0] lmul_log);
    return ((vlen >> 3) << lmul_log) >> sew_log;
  endfunction

endpackage

// File: rtl/vcfg_decode.sv
`timescale 1ns/1ps
module vcfg_decode #(
  parameter bit NEWER = 1'b0
) (
  input  logic [vcfg_pkg::IMM_W-1:0] imm,
  output vcfg_pkg::cfg_t             cfg
);

  generate
    if (NEWER) begin : g_newer
      always_comb cfg = vcfg_pkg::decode_newer(imm);
    end else begin : g_older
      always_comb cfg = vcfg_pkg::decode_older(imm);
    end
  endgenerate

endmodule

// File: rtl/vcfg_vlcalc.sv
`timescale 1ns/1ps
module vcfg_vlcalc #(
  parameter int XLEN = 32,
  parameter int VLEN = 128
) (
  input  vcfg_pkg::cfg_t   cfg,
  input  logic [XLEN-1:0]  avl,
  output logic [XLEN-1:0]  vlmax,
  output logic [XLEN-1:0]  grant
);

  always_comb begin
    vlmax = XLEN'(vcfg_pkg::vlmax_of(VLEN, cfg.sew_log, cfg.lmul_log));
    if (!cfg.legal)
      grant = '0;
    else if (avl < vlmax)
      grant = avl;
    else
      grant = vlmax;
  end

endmodule

// File: rtl/vcfg_state.sv
`timescale 1ns/1ps
module vcfg_state #(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  vcfg_pkg::cfg_t   cfg,
  input  logic [XLEN-1:0]  grant,
  output logic [XLEN-1:0]  vl_q,
  output logic [XLEN-1:0]  vtype_q,
  output logic             fp_ok_q,
  output logic             ack_q
);

  localparam logic [XLEN-1:0] ILL_WORD = {1'b1, {(XLEN-1){1'b0}}};

  logic [XLEN-1:0] vtype_next;

  always_comb begin
    vtype_next = '0;
    if (cfg.legal) begin
      vtype_next[2:0] = {1'b0, cfg.lmul_log};
      vtype_next[5:3] = {1'b0, cfg.sew_log};
      vtype_next[6]   = cfg.ta;
      vtype_next[7]   = cfg.ma;
    end else begin
      vtype_next = ILL_WORD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vl_q    <= '0;
      vtype_q <= ILL_WORD;
      fp_ok_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= load;
      if (load) begin
        vl_q    <= grant;
        vtype_q <= vtype_next;
        fp_ok_q <= cfg.legal && (cfg.sew_log == 2'd2);
      end
    end
  end

endmodule

// File: rtl/vcfg_unit.sv
`timescale 1ns/1ps
module vcfg_unit #(
  parameter int XLEN = 32,
  parameter int VLEN = 128
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_ratified,
  input  logic [XLEN-1:0]           req_avl,
  input  logic [vcfg_pkg::IMM_W-1:0] req_vtypei,
  output logic                      ack_o,
  output logic [XLEN-1:0]           vl_o,
  output logic [XLEN-1:0]           vtype_o,
  output logic                      fp_ok_o
);

  localparam int N_DIALECT = 2;

  vcfg_pkg::cfg_t  dec_cfg [N_DIALECT];
  vcfg_pkg::cfg_t  sel_cfg;
  logic            sel_legal;
  logic [XLEN-1:0] grp_vlmax;
  logic [XLEN-1:0] grant_vl;

  generate
    for (genvar g = 0; g < N_DIALECT; g++) begin : g_dec
      vcfg_decode #(.NEWER(g == 1)) u_dec (
        .imm (req_vtypei),
        .cfg (dec_cfg[g])
      );
    end
  endgenerate

  assign sel_cfg   = req_ratified ? dec_cfg[1] : dec_cfg[0];
  assign sel_legal = sel_cfg.legal;

  vcfg_vlcalc #(.XLEN(XLEN), .VLEN(VLEN)) u_calc (
    .cfg   (sel_cfg),
    .avl   (req_avl),
    .vlmax (grp_vlmax),
    .grant (grant_vl)
  );

  vcfg_state #(.XLEN(XLEN)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (req_valid),
    .cfg     (sel_cfg),
    .grant   (grant_vl),
    .vl_q    (vl_o),
    .vtype_q (vtype_o),
    .fp_ok_q (fp_ok_o),
    .ack_q   (ack_o)
  );

endmodule

// File: rtl/vcfg_unit_chk.sv
`timescale 1ns/1ps
module vcfg_unit_chk #(
  parameter int XLEN = 32,
  parameter int VLEN = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            sel_legal,
  input logic [XLEN-1:0] grant_vl,
  input logic            ack_o,
  input logic [XLEN-1:0] vl_o,
  input logic [XLEN-1:0] vtype_o,
  input logic            fp_ok_o
);

  // R2
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ack_o);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!ack_o && $stable(vl_o) && $stable(vtype_o) && $stable(fp_ok_o)));

  // R7
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sel_legal) |=> (vl_o == '0 && vtype_o[XLEN-1] && vtype_o[XLEN-2:0] == '0));

  // R6
  grant_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sel_legal) |=> (vl_o == $past(grant_vl) && !vtype_o[XLEN-1]));

  // R6
  vl_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vl_o <= XLEN'(VLEN));

  // R9
  fp_needs_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp_ok_o |-> (!vtype_o[XLEN-1] && vtype_o[5:3] == 3'b010));

  // R8
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vtype_o[XLEN-1] |-> (vtype_o[XLEN-2:8] == '0 && !vtype_o[2] && vtype_o[5:3] < 3'd3));

endmodule

bind vcfg_unit vcfg_unit_chk #(.XLEN(XLEN), .VLEN(VLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .sel_legal (sel_legal),
  .grant_vl  (grant_vl),
  .ack_o     (ack_o),
  .vl_o      (vl_o),
  .vtype_o   (vtype_o),
  .fp_ok_o   (fp_ok_o)
);

// File: tb/vcfg_unit_bench.sv
`timescale 1ns/1ps
module vcfg_unit_bench;

  localparam int XLEN = 32;
  localparam int VLEN = 128;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ratified = 1'b0;
  logic [XLEN-1:0] req_avl = '0;
  logic [7:0]      req_vtypei = '0;
  logic            ack_o;
  logic [XLEN-1:0] vl_o;
  logic [XLEN-1:0] vtype_o;
  logic            fp_ok_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5ns clk = ~clk;

  vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN)) u_vcfg_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ratified (req_ratified),
    .req_avl      (req_avl),
    .req_vtypei   (req_vtypei),
    .ack_o        (ack_o),
    .vl_o         (vl_o),
    .vtype_o      (vtype_o),
    .fp_ok_o      (fp_ok_o)
  );

  localparam logic [XLEN-1:0] ILL = 32'h8000_0000;

  // Independent model of the requirements.
  function automatic bit m_legal(input bit nw, input logic [7:0] imm);
    int w, g;
    if (nw) begin
      w = int'(imm[5:3]); g = int'(imm[2:0]);
      return (w <= 2) && (g <= 3);
    end
    w = int'(imm[4:2]);
    return (w <= 2) && (imm[7:5] == 3'b000);
  endfunction

  function automatic int m_wcode(input bit nw, input logic [7:0] imm);
    return nw ? int'(imm[5:3]) : int'(imm[4:2]);
  endfunction

  function automatic int m_gcode(input bit nw, input logic [7:0] imm);
    return nw ? int'(imm[2:0]) : int'(imm[1:0]);
  endfunction

  function automatic logic [XLEN-1:0] m_vl(input bit nw, input logic [7:0] imm,
                                           input logic [XLEN-1:0] avl);
    longint lmul, sew, vmax;
    if (!m_legal(nw, imm)) return '0;
    case (m_gcode(nw, imm)) 0: lmul = 1; 1: lmul = 2; 2: lmul = 4; default: lmul = 8; endcase
    case (m_wcode(nw, imm)) 0: sew = 8; 1: sew = 16; default: sew = 32; endcase
    vmax = (VLEN * lmul) / sew;
    if (longint'(avl) < vmax) return avl;
    return XLEN'(vmax);
  endfunction

  function automatic logic [XLEN-1:0] m_vtype(input bit nw, input logic [7:0] imm);
    logic [XLEN-1:0] t;
    if (!m_legal(nw, imm)) return ILL;
    t = XLEN'(m_gcode(nw, imm)) + (XLEN'(m_wcode(nw, imm)) * 8);
    if (nw) t = t + (imm[6] ? 32'd64 : 32'd0) + (imm[7] ? 32'd128 : 32'd0);
    return t;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic issue(input bit nw, input logic [7:0] imm, input logic [XLEN-1:0] avl);
    @(negedge clk);
    req_valid = 1'b1; req_ratified = nw; req_vtypei = imm; req_avl = avl;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_result(input string req, input bit nw, input logic [7:0] imm,
                               input logic [XLEN-1:0] avl);
    logic [XLEN-1:0] ev, et;
    ev = m_vl(nw, imm, avl);
    et = m_vtype(nw, imm);
    n_checks++;
    if (vl_o !== ev || vtype_o !== et || fp_ok_o !== (et == 32'h10 + (et & 32'hC7)) ||
        ack_o !== 1'b1) begin
      n_fail++;
      $display("FAIL %s imm=0x%02h dialect=%0d: actual vl=%0d vtype=0x%08h fp=%0b ack=%0b expected vl=%0d vtype=0x%08h fp=%0b ack=1",
               req, imm, nw, vl_o, vtype_o, fp_ok_o, ack_o, ev, et,
               (et == 32'h10 + (et & 32'hC7)));
    end
  endtask

  // R1
  task automatic t_reset();
    chk("R1", "vl", vl_o, '0);
    chk("R1", "vtype", vtype_o, ILL);
    chk("R1", "fp_ok", XLEN'(fp_ok_o), '0);
    chk("R1", "ack", XLEN'(ack_o), '0);
  endtask

  // R3 R4 R5 R7 R8 R9 R11: every immediate in both dialects
  task automatic t_sweep();
    int legal_cnt [2];
    for (int d = 0; d < 2; d++) begin
      legal_cnt[d] = 0;
      for (int i = 0; i < 256; i++) begin
        issue(d[0], 8'(i), 32'd1000);
        expect_result(d == 0 ? "R4" : "R5", d[0], 8'(i), 32'd1000);
        if (!vtype_o[XLEN-1]) legal_cnt[d]++;
      end
    end
    chk("R11", "legal count older", XLEN'(legal_cnt[0]), 32'd12);
    chk("R11", "legal count newer", XLEN'(legal_cnt[1]), 32'd48);
  endtask

  // R6: AVL around each grant limit
  task automatic t_avl_edges();
    logic [XLEN-1:0] lim;
    logic [XLEN-1:0] avls [5];
    for (int w = 0; w < 3; w++) begin
      for (int g = 0; g < 4; g++) begin
        lim = m_vl(1'b1, 8'(w * 8 + g), 32'hFFFF_FFFF);
        avls[0] = 0; avls[1] = lim - 1; avls[2] = lim; avls[3] = lim + 1;
        avls[4] = 32'hFFFF_FFFF;
        for (int k = 0; k < 5; k++) begin
          issue(1'b1, 8'(w * 8 + g), avls[k]);
          expect_result("R6", 1'b1, 8'(w * 8 + g), avls[k]);
        end
      end
    end
    issue(1'b0, 8'h00, 32'd40);
    chk("R6", "vl e8 m1 avl 40", vl_o, 32'd16);
    issue(1'b0, 8'h00, 32'd9);
    chk("R6", "vl e8 m1 avl 9", vl_o, 32'd9);
  endtask

  // R10: shared encodings
  task automatic t_shared();
    logic [XLEN-1:0] v0, t0;
    for (int i = 0; i < 4; i++) begin
      issue(1'b0, 8'(i), 32'd77);
      v0 = vl_o; t0 = vtype_o;
      issue(1'b1, 8'(i), 32'd77);
      chk("R10", "vl match", vl_o, v0);
      chk("R10", "vtype match", vtype_o, t0);
    end
  endtask

  // R2: idle cycles ignore the request inputs; ack is one cycle only
  task automatic t_hold();
    issue(1'b1, 8'hD1, 32'd5);
    expect_result("R2", 1'b1, 8'hD1, 32'd5);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      req_ratified = c[0]; req_vtypei = 8'(8'hFF - c); req_avl = 32'(c * 3);
      chk("R2", "idle ack", XLEN'(ack_o), '0);
      chk("R2", "idle vl", vl_o, 32'd5);
      chk("R2", "idle vtype", vtype_o, m_vtype(1'b1, 8'hD1));
    end
    // R7 then R9: illegal clears fp, wide legal sets it
    issue(1'b0, 8'h28, 32'd3);
    chk("R7", "vl after ill", vl_o, '0);
    chk("R7", "vtype after ill", vtype_o, ILL);
    issue(1'b0, 8'h0B, 32'd50);
    chk("R9", "fp_ok e32 m8", XLEN'(fp_ok_o), 32'd1);
    chk("R9", "vl e32 m8", vl_o, 32'd32);
    issue(1'b0, 8'h07, 32'd50);
    chk("R9", "fp_ok e16", XLEN'(fp_ok_o), 32'd0);
  endtask

  initial begin
    #900us;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sweep();
    t_avl_edges();
    t_shared();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule